// File: doc/BRIEF.md
# Scanning Matrix Keypad Encoder

This block reads a 4x4 matrix keypad by pulling one row line low at a time and watching the column lines, which the keypad wiring pulls high. A circular one-low shift register picks the active row and advances one row per clock while no column reads low. When a pressed key joins the active row to a column, that column goes low and the row register stops on that row. The row position and the lowest low column are each reduced to a 2-bit index, and the two indices are joined into a 4-bit key code.

The code is placed on a shared bus through a tristate driver. The driver is on only while the bus enable input is high and a key is seen. A key-present flag is produced at the same time. When every column returns high, the scan starts again on the next clock. Contact bounce and rules for several held keys are left to the logic around the block.

Top module: `kp_scan_encoder`

## Requirements
- R1: A clock edge with `rst` high puts `row_n` at 4'b1110, which drives row 0 low. This holds even while a column is low.
- R2: At every clock after reset, exactly one bit of `row_n` is 0.
- R3: At a clock edge where all `col_n` bits are 1, the low bit of `row_n` moves from row i to row (i+1) mod 4, so the order is 0, 1, 2, 3, 0.
- R4: At a clock edge where any `col_n` bit is 0, `row_n` keeps its value.
- R5: `key_valid` is 1 exactly when at least one `col_n` bit is 0. It follows the columns within the same cycle.
- R6: While driven, `data[3:2]` carries the index of the low row and `data[1:0]` carries the index of the low column. Row 0 with column 0 gives code 0, and row 3 with column 3 gives code 15.
- R7: When several `col_n` bits are 0, the column index in `data[1:0]` is the smallest index among them.
- R8: `data` is high-impedance whenever `output_enable` is 0 or `key_valid` is 0.
- R9: After all columns return high, the first clock edge advances the scan by one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_n | input | 4 | Column sense lines, active low, pulled up externally |
| output_enable | input | 1 | Bus enable for the key code driver |
| row_n | output | 4 | Row drive lines; exactly one is low |
| data | output | 4 | Key code {row, column}, or high-impedance |
| key_valid | output | 1 | A column is low, so a key in the driven row is down |

## Verification
A scan step and a key detection can fall on the same edge. This happens when a key is pressed in the row that the scan is just reaching. In that case the register must advance into that row and then stop there, without skipping past it. The bench models the keypad as a switch matrix that reacts at once to `row_n`. It presses keys at random times, including in the row about to be driven, and on each edge it predicts the row from its own model, step when every column is high and hold otherwise. Reset is also asserted while a key is held, to show that reset takes priority over the hold.

// File: rtl/kp_scan_pkg.sv
package kp_scan_pkg;

    localparam int KP_ROWS_DEFAULT = 4;
    localparam int KP_COLS_DEFAULT = 4;

    typedef enum logic {
        SCAN_RUN  = 1'b0,
        SCAN_HOLD = 1'b1
    } scan_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/kp_row_ring.sv
module kp_row_ring
    import kp_scan_pkg::*;
#(
    parameter int ROWS = KP_ROWS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    output logic [ROWS-1:0] row_n
);

    localparam logic [ROWS-1:0] START_N = ~(ROWS'(1));

    scan_mode_e mode;
    assign mode = hold ? SCAN_HOLD : SCAN_RUN;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_n <= START_N;
        end else if (mode == SCAN_RUN) begin
            row_n <= {row_n[ROWS-2:0], row_n[ROWS-1]};
        end
    end

    AST_RESET_ROW0: assert property (@(posedge clk)
        rst |=> row_n == START_N);  // R1

    AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_n) == 1);  // R2

    AST_RUN_ROTATES: assert property (@(posedge clk) disable iff (rst)
        mode == SCAN_RUN |=> row_n == {$past(row_n[ROWS-2:0]), $past(row_n[ROWS-1])});  // R3

endmodule

// File: rtl/kp_row_index.sv
module kp_row_index
    import kp_scan_pkg::*;
#(
    parameter int ROWS = KP_ROWS_DEFAULT,
    localparam int RW  = idx_width(ROWS)
) (
    input  logic [ROWS-1:0] row_n,
    output logic [RW-1:0]   row_idx
);

    always_comb begin
        row_idx = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (!row_n[i]) row_idx = RW'(i);
        end
    end

endmodule

// File: rtl/kp_col_index.sv
module kp_col_index
    import kp_scan_pkg::*;
#(
    parameter int COLS = KP_COLS_DEFAULT,
    localparam int CW  = idx_width(COLS)
) (
    input  logic [COLS-1:0] col_n,
    output logic [CW-1:0]   col_idx,
    output logic            any_low
);

    // Walk from the top so the lowest low column is written last.
    always_comb begin
        col_idx = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (!col_n[i]) col_idx = CW'(i);
        end
    end

    assign any_low = ~&col_n;

endmodule

// File: rtl/kp_scan_encoder.sv
module kp_scan_encoder
    import kp_scan_pkg::*;
#(
    parameter int ROWS    = KP_ROWS_DEFAULT,
    parameter int COLS    = KP_COLS_DEFAULT,
    localparam int RW     = idx_width(ROWS),
    localparam int CW     = idx_width(COLS),
    localparam int CODE_W = RW + CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COLS-1:0]   col_n,
    input  logic              output_enable,
    output logic [ROWS-1:0]   row_n,
    output logic [CODE_W-1:0] data,
    output logic              key_valid
);

    logic [RW-1:0]     row_idx;
    logic [CW-1:0]     col_idx;
    logic              col_hit;
    logic [CODE_W-1:0] key_code;

    kp_col_index #(.COLS(COLS)) u_col (
        .col_n   (col_n),
        .col_idx (col_idx),
        .any_low (col_hit)
    );

    kp_row_ring #(.ROWS(ROWS)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .hold  (col_hit),
        .row_n (row_n)
    );

    kp_row_index #(.ROWS(ROWS)) u_row (
        .row_n   (row_n),
        .row_idx (row_idx)
    );

    assign key_valid = col_hit;
    assign key_code  = {row_idx, col_idx};
    assign data      = (output_enable && key_valid) ? key_code : 'z;

    AST_HOLD_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> $stable(row_n));  // R4

    AST_ROW_MATCH: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> !row_n[row_idx]);  // R6

    AST_COL_SELECTED: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> !col_n[col_idx]);  // R7

    AST_COL_LOWEST: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ((~col_n) & ((COLS'(1) << col_idx) - COLS'(1))) == '0);  // R7

endmodule

// File: tb/sim_kp_scan_encoder.sv
`timescale 1ns/1ps
module sim_kp_scan_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oe  = 1'b0;
    logic [15:0] pressed = '0;   // bit r*4+c : key at row r, column c
    logic [3:0]  col_n;
    logic [3:0]  row_n;
    logic        key_valid;
    tri1  [3:0]  bus;            // pulled high when nobody drives

    int n_tests = 0;
    int n_fail  = 0;
    int exp_row = 0;

    always #5 clk = ~clk;

    // Switch matrix: a closed key shorts its column to its row line.
    always_comb begin
        col_n = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
    end

    kp_scan_encoder u0 (
        .clk           (clk),
        .rst           (rst),
        .col_n         (col_n),
        .output_enable (oe),
        .row_n         (row_n),
        .data          (bus),
        .key_valid     (key_valid)
    );

    function automatic logic [3:0] cols_in_row(input logic [15:0] p, input int r);
        return p[r*4 +: 4];
    endfunction

    function automatic int lowest(input logic [3:0] v);
        for (int c = 0; c < 4; c++) if (v[c]) return c;
        return 0;
    endfunction

    function automatic int next_row(input int cur, input logic [15:0] p, input logic r_in);
        if (r_in) return 0;
        if (cols_in_row(p, cur) != 4'h0) return cur;
        return (cur + 1) % 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        int nx;
        nx = next_row(exp_row, pressed, rst);
        @(posedge clk);
        exp_row = nx;
        @(negedge clk);
    endtask

    task automatic check_all();
        logic [3:0] hit;
        logic [3:0] want;
        hit = cols_in_row(pressed, exp_row);
        check(row_n == ~(4'b1 << exp_row), "R2/R3/R4 row_n", row_n, ~(4'b1 << exp_row));
        check(key_valid == (hit != 0), "R5 key_valid", key_valid, hit != 0);
        if (oe && hit != 0) begin
            want = {2'(exp_row), 2'(lowest(hit))};
            check(bus === want, "R6/R7 data", bus, want);
        end else begin
            check(bus === 4'hF, "R8 data undriven", bus, 4'hF);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        step();
        check(row_n == 4'b1110, "R1 reset row", row_n, 4'b1110);
        rst = 1'b0;

        // R3: free scan order 0,1,2,3,0
        for (int k = 0; k < 5; k++) begin
            step();
            check(row_n == ~(4'b1 << ((k + 1) % 4)), "R3 scan order", row_n, ~(4'b1 << ((k + 1) % 4)));
        end

        // R4/R6: press row 2 col 1 (code 9), wait until caught and hold
        oe = 1'b1;
        pressed = 16'h0200;
        for (int k = 0; k < 6; k++) begin
            step();
            check_all();
        end
        check(bus === 4'h9, "R6 code row2 col1", bus, 4'h9);

        // R8: bus disabled while key held
        oe = 1'b0;
        #1;
        check(bus === 4'hF, "R8 oe low", bus, 4'hF);
        oe = 1'b1;

        // R7: row 2 columns 3 and 1 together -> column 1
        pressed = 16'h0A00;
        #1;
        check(bus === 4'h9, "R7 lowest column", bus, 4'h9);

        // R9: release resumes on next edge
        pressed = '0;
        step();
        check(row_n == 4'b0111, "R9 resume", row_n, 4'b0111);

        // R6: row 3 column 3 is code 15; hold there for a few edges
        pressed = 16'h8000;
        step();
        check_all();
        check(bus === 4'hF && key_valid, "R6 code 15", bus, 4'hF);

        // R1: reset wins over a held key
        pressed = 16'h0001 | 16'h8000;
        rst = 1'b1;
        step();
        check(row_n == 4'b1110, "R1 reset with key", row_n, 4'b1110);
        rst = 1'b0;
        pressed = '0;
        step();

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            int sel;
            sel = $urandom % 10;
            if (sel < 4)      pressed = '0;
            else if (sel < 7) pressed = 16'(1) << ($urandom % 16);
            else if (sel < 9) pressed = 16'($urandom) & 16'($urandom);
            else              pressed = 16'(1) << (((exp_row + 1) % 4) * 4 + ($urandom % 4));
            oe = ($urandom % 4) != 0;
            step();
            check_all();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule